// File: doc/BRIEF.md
# Ripple-Carry Lane ALU with Signed Compare

This block is a purely combinational integer ALU made of a chain of one-bit lanes. Each lane holds a full adder and a four-way result selector. The selector chooses between the bitwise AND of the operands, their bitwise OR, the adder sum, and a per-lane "less" input. The chain supports AND, OR, add, subtract and a signed set-on-less-than compare. It returns the result together with a zero flag, a carry-out and a signed overflow flag.

Bit 2 of the operation code is a single negate line. It drives two things at once: it inverts operand b in every lane, and it is the carry into the lowest lane. Subtraction is therefore addition of the two's complement.

The compare takes the sum bit of the most significant lane, which is the sign of a minus b. That bit is fed back as the "less" input of lane 0, and every other lane sees a constant zero there. No correction is made for overflow. When a minus b overflows, the compare reports the raw sign of the difference, not the true signed ordering. The operand width is a parameter (default 32, minimum 2).

Top module: `alu_ripple`

## Requirements
- R1: Operation code 000 returns the bitwise AND of a and b.
- R2: Operation code 001 returns the bitwise OR of a and b.
- R3: Operation code 010 returns the low WIDTH bits of a+b, and the carry flag is bit WIDTH of that sum.
- R4: Operation code 110 returns a+~b+1 modulo 2^WIDTH. The carry flag is the carry out of the top lane, which is 1 exactly when a is greater than or equal to b as unsigned numbers.
- R5: For any code with bit 1 set, the overflow flag is 1 exactly when the two adder inputs to the top lane share a sign and the sum's sign differs from it. For codes with bit 1 clear, both the overflow flag and the carry flag are 0.
- R6: Operation code 111 returns zero in bits WIDTH-1..1. Bit 0 holds the top sum bit of a-b, which equals the true signed a<b XOR the overflow flag.
- R7: The zero flag is 1 exactly when every result bit is 0.
- R8: Bit 2 of the code inverts b in every lane and sets the carry-in, and bits 1:0 pick the lane output: 00 AND, 01 OR, 10 sum, 11 less. So 100 gives a AND NOT b, 101 gives a OR NOT b, and 011 gives the top sum bit of a+b in bit 0.
- R9: R1 to R8 hold for every operand pair and every code at WIDTH=4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 3 | Operation code: bit 2 negate, bits 1:0 lane select |
| result_o | output | WIDTH | Selected result |
| zero_o | output | 1 | All result bits are zero |
| carry_o | output | 1 | Carry out of the top lane for arithmetic codes |
| overflow_o | output | 1 | Signed overflow for arithmetic codes |

## Verification
Every output is combinational, so each result is due in the same cycle as its operands, after the carry has rippled through all lanes. No clock edge lies on the path. The bench drives a new operand pair and code, waits one nanosecond for the chain to settle, and then compares all four outputs against an arithmetic model. It drives nothing further until that comparison is done. The 32-bit instance is swept over a set of corner operands and random pairs. A 4-bit instance is swept exhaustively over all eight codes.

// File: rtl/alu_pkg.sv
// Package alu_pkg: operation codes, lane-select encoding and the one-bit
// helpers that every lane of the ripple ALU shares.
// Assumes: bit 2 of an operation code is the negate line; bits 1:0 select.
package alu_pkg;

    // Defined operation codes (bit 2 negate, bits 1:0 lane select)
    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    // Lane output selector, taken from the low two bits of the code
    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } alu_sel_e;

    // One-bit full adder: returns {carry_out, sum}
    function automatic logic [1:0] full_add(input logic x, input logic y, input logic cin);
        logic s;
        logic c;
        s = x ^ y ^ cin;
        c = (x & y) | (cin & (x ^ y));
        return {c, s};
    endfunction

    // Four-way lane output selector
    function automatic logic lane_pick(input alu_sel_e sel, input logic x, input logic y,
                                       input logic s, input logic less);
        logic r;
        case (sel)
            SEL_AND: r = x & y;
            SEL_OR:  r = x | y;
            SEL_SUM: r = s;
            default: r = less;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/alu_slice.sv
// Module alu_slice: one ordinary lane of the ripple ALU. Inverts b when
// negate is set, adds with the incoming carry, and selects AND, OR, sum
// or the externally supplied less input.
// Assumes: purely combinational; the carry chain is wired by the parent.
module alu_slice
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     negate_i,
    input  logic     carry_i,
    input  logic     less_i,
    input  alu_sel_e sel_i,
    output logic     res_o,
    output logic     carry_o
);

    logic b_eff;
    logic [1:0] add_w;

    // Operand inversion and full add for this lane
    always_comb begin
        b_eff = b_i ^ negate_i;
        add_w = full_add(a_i, b_eff, carry_i);
    end

    // Lane result selection and carry forwarding
    always_comb begin
        res_o   = lane_pick(sel_i, a_i, b_eff, add_w[0], less_i);
        carry_o = add_w[1];
    end

endmodule

// File: rtl/alu_msb_slice.sv
// Module alu_msb_slice: the most significant lane. Behaves like an ordinary
// lane and also exports its raw sum bit (the compare source) and the
// signed-overflow indication (carry in differs from carry out).
// Assumes: the parent gates overflow for non-arithmetic codes.
module alu_msb_slice
    import alu_pkg::*;
(
    input  logic     a_i,
    input  logic     b_i,
    input  logic     negate_i,
    input  logic     carry_i,
    input  logic     less_i,
    input  alu_sel_e sel_i,
    output logic     res_o,
    output logic     carry_o,
    output logic     set_o,
    output logic     ovf_o
);

    logic b_eff;
    logic [1:0] add_w;

    // Operand inversion and full add for the top lane
    always_comb begin
        b_eff = b_i ^ negate_i;
        add_w = full_add(a_i, b_eff, carry_i);
    end

    // Result, carry, compare source and overflow detection
    always_comb begin
        res_o   = lane_pick(sel_i, a_i, b_eff, add_w[0], less_i);
        carry_o = add_w[1];
        set_o   = add_w[0];
        ovf_o   = carry_i ^ add_w[1];
    end

endmodule

// File: rtl/alu_zero_detect.sv
// Module alu_zero_detect: flags a result vector that is all zeros.
// Assumes: WIDTH >= 1; purely combinational.
module alu_zero_detect #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] value_i,
    output logic             all_clear_o
);

    // NOR reduction over the whole result
    always_comb begin
        all_clear_o = ~|value_i;
    end

endmodule

// File: rtl/alu_ripple.sv
// Module alu_ripple: combinational ALU built as a chain of one-bit lanes.
// Bit 2 of op_i is one negate line (b inversion plus carry-in of lane 0),
// bits 1:0 select the lane output. The top lane's sum bit is routed back as
// lane 0's less input; all other lanes see zero there.
// Assumes: WIDTH >= 2. No clock; results settle after the carry ripple.
module alu_ripple
    import alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             overflow_o
);

    localparam int MSB = WIDTH - 1;

    logic            negate;
    logic            arith;
    alu_sel_e        sel;
    logic [WIDTH:0]  carry;
    logic            set_w;
    logic            ovf_raw;
    logic [WIDTH-1:0] res_w;

    // Split the operation code into negate, select and arithmetic qualifier
    always_comb begin
        negate = op_i[2];
        arith  = op_i[1];
        sel    = alu_sel_e'(op_i[1:0]);
    end

    assign carry[0] = negate;

    // Lane chain: lane 0 receives the compare source, the rest receive zero
    for (genvar i = 0; i < MSB; i++) begin : g_lane
        if (i == 0) begin : g_lsb
            alu_slice u_lane (
                .a_i      (a_i[i]),
                .b_i      (b_i[i]),
                .negate_i (negate),
                .carry_i  (carry[i]),
                .less_i   (set_w),
                .sel_i    (sel),
                .res_o    (res_w[i]),
                .carry_o  (carry[i+1])
            );
        end else begin : g_mid
            alu_slice u_lane (
                .a_i      (a_i[i]),
                .b_i      (b_i[i]),
                .negate_i (negate),
                .carry_i  (carry[i]),
                .less_i   (1'b0),
                .sel_i    (sel),
                .res_o    (res_w[i]),
                .carry_o  (carry[i+1])
            );
        end
    end

    alu_msb_slice u_top (
        .a_i      (a_i[MSB]),
        .b_i      (b_i[MSB]),
        .negate_i (negate),
        .carry_i  (carry[MSB]),
        .less_i   (1'b0),
        .sel_i    (sel),
        .res_o    (res_w[MSB]),
        .carry_o  (carry[WIDTH]),
        .set_o    (set_w),
        .ovf_o    (ovf_raw)
    );

    alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
        .value_i     (res_w),
        .all_clear_o (zero_o)
    );

    // Drive outputs; flags only report for arithmetic codes
    always_comb begin
        result_o   = res_w;
        carry_o    = arith & carry[WIDTH];
        overflow_o = arith & ovf_raw;
    end

    // Output invariants checked against the operands
    always_comb begin
        // R5: logical codes never raise carry or overflow
        if (!op_i[1]) begin
            p_no_overflow_r5: assert (!overflow_o && !carry_o);
        end
        // R5: operands of opposite sign cannot overflow an add
        if (op_i == OP_ADD && (a_i[MSB] != b_i[MSB])) begin
            p_mixed_sign_add_r5: assert (!overflow_o);
        end
        // R4: subtract carry means unsigned a >= b
        if (op_i == OP_SUB) begin
            p_sub_carry_r4: assert (carry_o == (a_i >= b_i));
        end
        // R6: compare result is raw sign of a-b
        if (op_i == OP_SLT) begin
            p_slt_raw_sign_r6: assert (result_o[MSB:1] == '0 &&
                result_o[0] == (overflow_o ^ ($signed(a_i) < $signed(b_i))));
        end
        // R7: zero flag tracks the result vector
        p_zero_flag_r7: assert (zero_o == (result_o == '0));
    end

endmodule

// File: tb/sim_alu_ripple.sv
// Bench sim_alu_ripple: corner and random sweeps at WIDTH=32 and an
// exhaustive sweep at WIDTH=4, checked against an arithmetic model.
module sim_alu_ripple;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #2 clk = ~clk;

    logic [31:0] a32, b32, r32;
    logic [2:0]  op32;
    logic        z32, c32, v32;
    logic [3:0]  a4, b4, r4;
    logic [2:0]  op4;
    logic        z4, c4, v4;

    alu_ripple #(.WIDTH(32)) u0 (
        .a_i(a32), .b_i(b32), .op_i(op32),
        .result_o(r32), .zero_o(z32), .carry_o(c32), .overflow_o(v32)
    );

    alu_ripple #(.WIDTH(4)) u1 (
        .a_i(a4), .b_i(b4), .op_i(op4),
        .result_o(r4), .zero_o(z4), .carry_o(c4), .overflow_o(v4)
    );

    // Arithmetic model of the requirements for width w (2..32)
    function automatic void model(input int w, input logic [31:0] a, input logic [31:0] b,
                                  input logic [2:0] op, output logic [31:0] r,
                                  output logic co, output logic ov, output logic z);
        logic [31:0] mask;
        logic [31:0] bb;
        logic [32:0] s;
        logic [31:0] sum;
        logic        cout;
        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        bb   = op[2] ? (~b & mask) : (b & mask);
        s    = {1'b0, a & mask} + {1'b0, bb} + {32'd0, op[2]};
        cout = s[w];
        sum  = s[31:0] & mask;
        case (op[1:0])
            2'b00:   r = a & bb;
            2'b01:   r = a | bb;
            2'b10:   r = sum;
            default: r = {31'd0, sum[w-1]};
        endcase
        r  = r & mask;
        co = op[1] & cout;
        ov = op[1] & (a[w-1] == bb[w-1]) & (sum[w-1] != a[w-1]);
        z  = (r == 32'd0);
    endfunction

    function automatic string res_tag(input logic [2:0] op);
        case (op)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b110:  return "R4";
            3'b111:  return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic compare(input string tag, input logic [31:0] act, input logic [31:0] exp,
                           input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s op=%b a=%h b=%h actual=%h expected=%h", tag, op, a, b, act, exp);
        end
    endtask

    task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic [2:0] op);
        logic [31:0] er;
        logic ec, ev, ez;
        a32 = a; b32 = b; op32 = op;
        #1;
        model(32, a, b, op, er, ec, ev, ez);
        compare(res_tag(op), r32, er, a, b, op);
        compare(op[2] ? "R4 carry" : "R3 carry", {31'd0, c32}, {31'd0, ec}, a, b, op);
        compare("R5 overflow", {31'd0, v32}, {31'd0, ev}, a, b, op);
        compare("R7 zero", {31'd0, z32}, {31'd0, ez}, a, b, op);
    endtask

    task automatic run4(input logic [3:0] a, input logic [3:0] b, input logic [2:0] op);
        logic [31:0] er;
        logic ec, ev, ez;
        a4 = a; b4 = b; op4 = op;
        #1;
        model(4, {28'd0, a}, {28'd0, b}, op, er, ec, ev, ez);
        compare("R9 result", {28'd0, r4}, er, {28'd0, a}, {28'd0, b}, op);
        compare("R9 carry", {31'd0, c4}, {31'd0, ec}, {28'd0, a}, {28'd0, b}, op);
        compare("R9 overflow", {31'd0, v4}, {31'd0, ev}, {28'd0, a}, {28'd0, b}, op);
        compare("R9 zero", {31'd0, z4}, {31'd0, ez}, {28'd0, a}, {28'd0, b}, op);
    endtask

    logic [31:0] corners [7];

    initial begin
        corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
        corners[2] = 32'hFFFF_FFFF; corners[3] = 32'h8000_0000;
        corners[4] = 32'h7FFF_FFFF; corners[5] = 32'h5555_5555;
        corners[6] = 32'hAAAA_AAAA;
        a32 = '0; b32 = '0; op32 = '0; a4 = '0; b4 = '0; op4 = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Corner pairs over all eight codes (R1..R8, incl. overflowing compares for R6)
        for (int i = 0; i < 7; i++)
            for (int j = 0; j < 7; j++)
                for (int k = 0; k < 8; k++)
                    run32(corners[i], corners[j], 3'(k));
        // Random operand pairs over all codes
        for (int n = 0; n < 2000; n++)
            run32($urandom, $urandom, 3'($urandom % 8));
        // Exhaustive 4-bit sweep (R9)
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int k = 0; k < 8; k++)
                    run4(4'(a), 4'(b), 3'(k));
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule